// File: doc/BRIEF.md
# Blanking-Gated Horizontal Clock Widener

The block generates a complementary pair of horizontal shift-clock phases for sensor readout. Time advances on a half-pixel step enable, `hstep_i`, which pulses twice per pixel. Outside the line blanking interval, the phase output toggles on every step. That gives one full clock period per pixel.

While blanking is asserted, the block can slow the clock with a 4-bit width code N. For N from 1 to 15, each phase lasts 2N steps, which is N pixels. The clock then runs at 1/(2N) of the pixel rate, so code 1 doubles the pulse width. Code 0 keeps the pixel rate during blanking. Widening is refused in blanking modes 2 and 3.

Each time the block enters widened operation, it restarts its divide counter and begins a full-length high phase. When blanking drops, pixel-rate toggling resumes on the very next step.

Top module: `hclk_widener`

## Requirements
- R1: While `rst_ni` is low, and after it rises with no step, `hclk_p_o` is 0 and `hclk_n_o` is 1.
- R2: The outputs change only in the clock cycle that follows a cycle with `hstep_i` high; in every other cycle they hold.
- R3: On a step with `blank_i` low, `hclk_p_o` inverts.
- R4: With width code 0, a step inside blanking inverts `hclk_p_o`, exactly as outside blanking.
- R5: With `blank_i` high, code N in 1..15 and mode 0 or 1, each phase of `hclk_p_o` lasts exactly 2N steps. That is N pixels, or a frequency of 1/(2N) of the pixel rate.
- R6: Mode encodings 2'd2 and 2'd3 ignore the width code: every step inverts `hclk_p_o`, even inside blanking.
- R7: `hclk_n_o` is always the inverse of `hclk_p_o`.
- R8: On the first widened step (entry into blanking with widening enabled), `hclk_p_o` becomes 1. It stays 1 for 2N steps counted from that step, then goes low for 2N steps.
- R9: On the first step after widened operation ends, `hclk_p_o` inverts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hstep_i | input | 1 | Half-pixel step enable |
| blank_i | input | 1 | Line blanking active |
| width_code_i | input | 4 | Widening code N (0 = off) |
| blank_mode_i | input | 2 | Blanking mode; 0 and 1 allow widening |
| hclk_p_o | output | 1 | Horizontal clock phase |
| hclk_n_o | output | 1 | Complementary horizontal clock phase |

## Verification
The bench sweeps every width code in every mode. For each pairing it runs steps before, during and after blanking, and compares every output sample with an arithmetic phase model.

Several faults would show up in this sweep:
- A counter that is off by one would give phases of 2N±1 steps in R5.
- A counter not restarted on entry would produce a truncated first high phase (R8).
- Decoding modes 2 and 3 wrongly would widen clocks that should stay at pixel rate (R6).
- Holding the wide phase past blanking exit would leave the output frozen on the first normal step (R9).

The idle cycle between steps exposes any output that moves without a step (R2).

// File: rtl/hclk_pkg.sv
package hclk_pkg;
  localparam int CODE_W = 4;
  localparam int LEN_W  = CODE_W + 1;

  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'd0,
    MODE_REPEAT  = 2'd1,
    MODE_PATTERN = 2'd2,
    MODE_RSVD    = 2'd3
  } blank_mode_e;

  function automatic logic mode_allows_wide(blank_mode_e m);
    return (m == MODE_SINGLE) || (m == MODE_REPEAT);
  endfunction
endpackage

// File: rtl/hclk_rate_sel.sv
module hclk_rate_sel
  import hclk_pkg::*;
#(
  parameter int CW = CODE_W,
  localparam int LW = CW + 1
) (
  input  logic          blank_i,
  input  logic [CW-1:0] code_i,
  input  logic [1:0]    mode_i,
  output logic          wide_o,
  output logic [LW-1:0] len_o
);
  blank_mode_e mode;
  assign mode   = blank_mode_e'(mode_i);
  assign wide_o = blank_i && (code_i != '0) && mode_allows_wide(mode);
  // phase length in half-pixel steps = 2N
  assign len_o  = {code_i, 1'b0};
endmodule

// File: rtl/hclk_div_cnt.sv
module hclk_div_cnt #(
  parameter int LW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          wide_i,
  input  logic [LW-1:0] len_i,
  output logic          entry_o,
  output logic          phase_end_o
);
  logic [LW-1:0] cnt_q;
  logic          wide_q;
  logic          at_end;

  assign at_end      = cnt_q >= len_i;
  assign entry_o     = step_i && wide_i && !wide_q;
  assign phase_end_o = step_i && wide_i && wide_q && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wide_q <= 1'b0;
    end else if (step_i) begin
      wide_q <= wide_i;
      if (!wide_i)        cnt_q <= '0;
      else if (!wide_q)   cnt_q <= LW'(1);  // restart on entry
      else if (at_end)    cnt_q <= LW'(1);
      else                cnt_q <= cnt_q + LW'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_q |-> cnt_q <= len_i || !wide_i || $changed(len_i)); // R5
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/hclk_widener.sv
module hclk_widener
  import hclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hstep_i,
  input  logic              blank_i,
  input  logic [CODE_W-1:0] width_code_i,
  input  logic [1:0]        blank_mode_i,
  output logic              hclk_p_o,
  output logic              hclk_n_o
);
  logic             wide;
  logic [LEN_W-1:0] len;
  logic             entry;
  logic             phase_end;
  logic             p_q, n_q;

  hclk_rate_sel #(.CW(CODE_W)) u_rate_sel (
    .blank_i (blank_i),
    .code_i  (width_code_i),
    .mode_i  (blank_mode_i),
    .wide_o  (wide),
    .len_o   (len)
  );

  hclk_div_cnt #(.LW(LEN_W)) u_div_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (hstep_i),
    .wide_i      (wide),
    .len_i       (len),
    .entry_o     (entry),
    .phase_end_o (phase_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q <= 1'b0;
      n_q <= 1'b1;
    end else if (entry) begin
      p_q <= 1'b1;
      n_q <= 1'b0;
    end else if (hstep_i && (!wide || phase_end)) begin
      p_q <= ~p_q;
      n_q <= ~n_q;
    end
  end

  assign hclk_p_o = p_q;
  assign hclk_n_o = n_q;

  AST_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hclk_p_o != hclk_n_o); // R7
  AST_NO_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hstep_i |=> $stable(hclk_p_o)); // R2
  AST_NARROW_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hstep_i && !blank_i) |=> hclk_p_o != $past(hclk_p_o)); // R3
  AST_MODE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hstep_i && blank_mode_i[1]) |=> hclk_p_o != $past(hclk_p_o)); // R6
  AST_ENTRY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry |=> hclk_p_o); // R8
endmodule

// File: tb/hclk_widener_tb.sv
module hclk_widener_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hstep_i = 1'b0;
  logic       blank_i = 1'b0;
  logic [3:0] width_code_i = '0;
  logic [1:0] blank_mode_i = '0;
  logic       hclk_p_o, hclk_n_o;

  int checks = 0;
  int errors = 0;
  logic exp_p = 1'b0;
  int   k = 0;
  logic was_wide = 1'b0;
  logic done = 1'b0;

  always #5 clk_i = ~clk_i;

  hclk_widener u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hstep_i(hstep_i), .blank_i(blank_i),
    .width_code_i(width_code_i), .blank_mode_i(blank_mode_i),
    .hclk_p_o(hclk_p_o), .hclk_n_o(hclk_n_o)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b mode=%0d code=%0d k=%0d",
               req, act, exp, blank_mode_i, width_code_i, k);
    end
  endtask

  // one step: pulse hstep for a cycle, then one idle cycle
  task automatic step(logic blk);
    logic wide;
    string req;
    blank_i = blk;
    wide = blk && (width_code_i != 0) && (blank_mode_i < 2);
    if (wide) begin
      if (!was_wide) k = 0; else k++;
      exp_p = ((k / (2 * int'(width_code_i))) % 2) == 0;
      req = (k == 0) ? "R8" : "R5";
    end else begin
      exp_p = ~exp_p;
      if (was_wide)              req = "R9";
      else if (!blk)             req = "R3";
      else if (blaNk_dummy())    req = "R6";
      else                       req = "R4";
    end
    was_wide = wide;
    hstep_i = 1'b1;
    @(negedge clk_i);
    hstep_i = 1'b0;
    check(req, hclk_p_o, exp_p);
    check("R7", hclk_n_o, ~exp_p);
    @(negedge clk_i);
    check("R2", hclk_p_o, exp_p);
  endtask

  function automatic logic blaNk_dummy();
    return blank_mode_i >= 2;
  endfunction

  initial begin
    #10000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    check("R1", hclk_p_o, 1'b0);
    check("R1", hclk_n_o, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", hclk_p_o, 1'b0);
    check("R1", hclk_n_o, 1'b1);
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 16; c++) begin
        blank_mode_i = 2'(m);
        width_code_i = 4'(c);
        for (int i = 0; i < 3 + (c % 2); i++) step(1'b0);
        for (int i = 0; i < 4 * 2 * (c == 0 ? 1 : c) + 3; i++) step(1'b1);
        for (int i = 0; i < 4; i++) step(1'b0);
      end
    end
    // back-to-back blanking with one normal step between
    blank_mode_i = 2'd1;
    width_code_i = 4'd3;
    for (int i = 0; i < 9; i++) step(1'b1);
    step(1'b0);
    for (int i = 0; i < 13; i++) step(1'b1);
    step(1'b0);
    step(1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule